// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a real page address through a small set of block-translation entries. It does this in the same cycle as the request. Each entry is a pair of 32-bit words, an upper word and a lower word. Instruction fetches search their own entry array, and loads and stores search a separate data array. Along with the translated page, the unit reports whether any entry matched, which of read, write and execute the matched block permits, and whether the requested access breaks those permissions. On a protection fault it returns a status code. For data accesses it also registers the faulting address.

The entry words are loaded through a simple synchronous write port. One write selects the array, the entry index, and the upper or lower half. A static `legacy_mode` input selects an older entry layout. In that layout the valid bit and the block length live in the lower word, and the upper word holds a pair of privilege keys. The only clocked state is the entry storage and the captured fault address. There is no sequencing state machine: the registers load on a write, and they reset to zero.

Top module: `bat_xlate_unit`

## Requirements
- R1: A request with `acc_kind` = 2 (fetch) searches only the instruction array. Codes 0 (load), 1 (store) and 3 (treated as a load) search only the data array. A write lands in the instruction array when `cfg_wr_fetch_side` = 1, and in the upper word when `cfg_wr_lower` = 0.
- R2: After reset, every entry word is zero, so no request hits.
- R3: In normal layout, an entry takes part only if upper bit 0 is set in user mode (`user_mode` = 1), or upper bit 1 is set in supervisor mode.
- R4: In normal layout the match mask is 0xFFFE0000 with ((upper AND 0x1FFC) << 15) cleared out of it. An entry matches when (address AND mask) equals (upper AND 0xFFFE0000). On a miss, `real_page`, the permission bits, `prot_fault` and `fault_code` are all zero.
- R5: On a hit, `real_page` = ((lower AND mask) OR (address AND NOT mask)) AND 0xFFFFF000.
- R6: In normal layout, lower bits 1:0 give the permissions: 00 gives none, 01 and 11 give read, 10 gives read and write. Execute always equals read.
- R7: In legacy layout, lower bit 6 is the valid bit for both privileges. The mask clears ((lower AND 0x3F) << 17). The key is upper bit 2 in user mode and upper bit 3 in supervisor mode. With upper bits 1:0 as pp: key 0 gives read/write except pp=11, which gives read only. Key 1 gives none for pp=00, read/write for pp=10, and read only otherwise. Execute equals read.
- R8: `prot_fault` is set on a hit whose permissions lack what the access needs. A fetch needs execute, a store needs write, and any other code needs read. `fault_code` is 0x0A000000 for a store fault and 0x08000000 for any other fault.
- R9: On the clock edge of a cycle with a non-fetch protection fault, `fault_addr` loads the effective address. Otherwise it holds its value. It resets to zero.
- R10: When several entries match, the lowest-numbered one supplies the page and the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Entry word write strobe |
| cfg_wr_fetch_side | input | 1 | 1 writes the instruction array, 0 the data array |
| cfg_wr_idx | input | IDX_W | Entry index to write |
| cfg_wr_lower | input | 1 | 1 writes the lower word, 0 the upper word |
| cfg_wr_data | input | 32 | Word to write |
| legacy_mode | input | 1 | Selects the legacy entry layout |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| eff_addr | input | 32 | Effective address |
| hit | output | 1 | Some active entry matched |
| real_page | output | 32 | Translated 4 KB page address |
| perm_rd | output | 1 | Matched block permits read |
| perm_wr | output | 1 | Matched block permits write |
| perm_ex | output | 1 | Matched block permits execute |
| prot_fault | output | 1 | Access violates the matched block's permissions |
| fault_code | output | 32 | Status word for the fault, zero otherwise |
| fault_addr | output | 32 | Address of the last data-side protection fault |

## Verification
The translation is tried in three ways. First, addresses inside and outside blocks of the minimum and maximum lengths, which separates the length masking from the fixed page-index compare. Second, overlapping entries with different real pages, which shows whether the lowest index wins. Third, the same entry read under both privileges and both layouts, which separates the per-privilege valid bits from the legacy valid bit and the two keys. A long random phase then mixes writes to both arrays with all four access codes. Addresses are biased toward configured blocks, and every output is compared each cycle against a behavioural model. This exercises array selection, fault codes and fault-address capture against misses and fetches.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    localparam int          WORD_W          = 32;
    localparam logic [31:0] PAGE_IDX_MASK   = 32'hFFFE_0000;
    localparam logic [31:0] FRAME_MASK      = 32'hFFFF_F000;
    localparam logic [31:0] NORM_LEN_MASK   = 32'h0000_1FFC;
    localparam int          NORM_LEN_SHIFT  = 15;
    localparam logic [31:0] LEG_LEN_MASK    = 32'h0000_003F;
    localparam int          LEG_LEN_SHIFT   = 17;
    localparam int          NORM_USR_VALID  = 0;
    localparam int          NORM_SUP_VALID  = 1;
    localparam int          LEG_VALID       = 6;
    localparam int          LEG_USR_KEY     = 2;
    localparam int          LEG_SUP_KEY     = 3;
    localparam logic [31:0] CODE_DENIED     = 32'h0800_0000;
    localparam logic [31:0] CODE_ST_DENIED  = 32'h0A00_0000;

    // Normal layout: two-bit protection field, execute follows read.
    function automatic perm_t decode_plain(input logic [1:0] pp);
        perm_t p;
        unique case (pp)
            2'b00:   p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
            2'b10:   p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        endcase
        return p;
    endfunction

    // Legacy layout: a privilege key qualifies the protection field.
    function automatic perm_t decode_keyed(input logic key, input logic [1:0] pp);
        perm_t p;
        if (!key) begin
            p = (pp == 2'b11) ? '{rd: 1'b1, wr: 1'b0, ex: 1'b1}
                              : '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
        end else begin
            unique case (pp)
                2'b00:   p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
                2'b10:   p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/bat_bank.sv
module bat_bank #(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_lower,
    input  logic [31:0]                   wr_data,
    output logic [NUM_ENTRIES-1:0][31:0]  upper_q,
    output logic [NUM_ENTRIES-1:0][31:0]  lower_q
);

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    upper_q[g] <= '0;
                    lower_q[g] <= '0;
                end else if (sel) begin
                    if (wr_lower) lower_q[g] <= wr_data;
                    else          upper_q[g] <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_xlate_pkg::*;
(
    input  logic [31:0] upper,
    input  logic [31:0] lower,
    input  logic [31:0] eff_addr,
    input  logic        legacy_mode,
    input  logic        user_mode,
    output logic        match,
    output logic [31:0] page,
    output perm_t       perm
);

    logic        active;
    logic [31:0] len_bits;
    logic [31:0] mask;
    logic        key;

    always_comb begin
        if (legacy_mode) begin
            active   = lower[LEG_VALID];
            len_bits = (lower & LEG_LEN_MASK) << LEG_LEN_SHIFT;
            key      = user_mode ? upper[LEG_USR_KEY] : upper[LEG_SUP_KEY];
            perm     = decode_keyed(key, upper[1:0]);
        end else begin
            active   = user_mode ? upper[NORM_USR_VALID] : upper[NORM_SUP_VALID];
            len_bits = (upper & NORM_LEN_MASK) << NORM_LEN_SHIFT;
            key      = 1'b0;
            perm     = decode_plain(lower[1:0]);
        end
        mask  = active ? (PAGE_IDX_MASK & ~len_bits) : '0;
        match = (mask != '0) && ((eff_addr & mask) == (upper & PAGE_IDX_MASK));
        page  = ((lower & mask) | (eff_addr & ~mask)) & FRAME_MASK;
    end

endmodule

// File: rtl/bat_pick.sv
module bat_pick
    import bat_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic [NUM_ENTRIES-1:0]        match,
    input  logic [NUM_ENTRIES-1:0][31:0]  page_in,
    input  perm_t [NUM_ENTRIES-1:0]       perm_in,
    output logic                          hit,
    output logic [31:0]                   page,
    output perm_t                         perm
);

    // Walk from the top index down so the lowest matching index is left standing.
    always_comb begin
        hit  = 1'b0;
        page = '0;
        perm = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                page = page_in[i];
                perm = perm_in[i];
            end
        end
    end

endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
    import bat_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_fetch_side,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              cfg_wr_lower,
    input  logic [31:0]       cfg_wr_data,
    input  logic              legacy_mode,
    input  logic              user_mode,
    input  logic [1:0]        acc_kind,
    input  logic [31:0]       eff_addr,
    output logic              hit,
    output logic [31:0]       real_page,
    output logic              perm_rd,
    output logic              perm_wr,
    output logic              perm_ex,
    output logic              prot_fault,
    output logic [31:0]       fault_code,
    output logic [31:0]       fault_addr
);

    acc_kind_e kind;
    logic      is_fetch;
    assign kind     = acc_kind_e'(acc_kind);
    assign is_fetch = (kind == ACC_FETCH);

    logic [NUM_ENTRIES-1:0][31:0] ib_upper, ib_lower, db_upper, db_lower;

    bat_bank #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ibank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en && cfg_wr_fetch_side),
        .wr_idx   (cfg_wr_idx),
        .wr_lower (cfg_wr_lower),
        .wr_data  (cfg_wr_data),
        .upper_q  (ib_upper),
        .lower_q  (ib_lower)
    );

    bat_bank #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en && !cfg_wr_fetch_side),
        .wr_idx   (cfg_wr_idx),
        .wr_lower (cfg_wr_lower),
        .wr_data  (cfg_wr_data),
        .upper_q  (db_upper),
        .lower_q  (db_lower)
    );

    logic [NUM_ENTRIES-1:0][31:0] sel_upper, sel_lower, ent_page;
    logic [NUM_ENTRIES-1:0]       ent_match;
    perm_t [NUM_ENTRIES-1:0]      ent_perm;

    assign sel_upper = is_fetch ? ib_upper : db_upper;
    assign sel_lower = is_fetch ? ib_lower : db_lower;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_eval
            bat_entry_eval u_eval (
                .upper       (sel_upper[g]),
                .lower       (sel_lower[g]),
                .eff_addr    (eff_addr),
                .legacy_mode (legacy_mode),
                .user_mode   (user_mode),
                .match       (ent_match[g]),
                .page        (ent_page[g]),
                .perm        (ent_perm[g])
            );
        end
    endgenerate

    perm_t win_perm;

    bat_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .match   (ent_match),
        .page_in (ent_page),
        .perm_in (ent_perm),
        .hit     (hit),
        .page    (real_page),
        .perm    (win_perm)
    );

    assign perm_rd = win_perm.rd;
    assign perm_wr = win_perm.wr;
    assign perm_ex = win_perm.ex;

    logic granted;
    always_comb begin
        unique case (kind)
            ACC_STORE: granted = win_perm.wr;
            ACC_FETCH: granted = win_perm.ex;
            default:   granted = win_perm.rd;
        endcase
    end

    assign prot_fault = hit && !granted;
    assign fault_code = !prot_fault         ? 32'h0 :
                        (kind == ACC_STORE) ? CODE_ST_DENIED : CODE_DENIED;

    logic [31:0] fault_addr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        fault_addr_q <= '0;
        else if (prot_fault && !is_fetch)  fault_addr_q <= eff_addr;
    end
    assign fault_addr = fault_addr_q;

endmodule

// File: rtl/bat_xlate_checker.sv
module bat_xlate_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  acc_kind,
    input logic [31:0] eff_addr,
    input logic        hit,
    input logic [31:0] real_page,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        perm_ex,
    input logic        prot_fault,
    input logic [31:0] fault_code,
    input logic [31:0] fault_addr
);

    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (real_page == 32'h0) && !perm_rd && !perm_wr && !perm_ex && !prot_fault);

    assert_page_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        real_page[11:0] == 12'h0);

    assert_exec_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (perm_ex == perm_rd));

    assert_fault_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> hit);

    assert_store_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault && acc_kind == 2'd1) |-> (fault_code == 32'h0A00_0000));

    assert_quiet_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_fault |-> (fault_code == 32'h0));

    assert_fault_addr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault && acc_kind != 2'd2) |=> (fault_addr == $past(eff_addr)));

    assert_fault_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(prot_fault && acc_kind != 2'd2) |=> $stable(fault_addr));

    assert_reset_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit);

endmodule

bind bat_xlate_unit bat_xlate_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_kind   (acc_kind),
    .eff_addr   (eff_addr),
    .hit        (hit),
    .real_page  (real_page),
    .perm_rd    (perm_rd),
    .perm_wr    (perm_wr),
    .perm_ex    (perm_ex),
    .prot_fault (prot_fault),
    .fault_code (fault_code),
    .fault_addr (fault_addr)
);

// File: tb/bat_xlate_unit_test.sv
module bat_xlate_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_fetch_side = 1'b0;
    logic [1:0]  cfg_wr_idx = '0;
    logic        cfg_wr_lower = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        legacy_mode = 1'b0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] eff_addr = '0;
    logic        hit, perm_rd, perm_wr, perm_ex, prot_fault;
    logic [31:0] real_page, fault_code, fault_addr;

    bat_xlate_unit #(.NUM_ENTRIES(NE), .IDX_W(2)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [31:0] m_up [2][NE];
    logic [31:0] m_lo [2][NE];
    logic [31:0] m_faddr;
    logic        e_hit, e_r, e_w, e_x, e_fault;
    logic [31:0] e_page, e_code;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_eval();
        int side;
        logic [31:0] u, l, m;
        logic v, k, r, w, ok;
        logic [1:0] pp;
        side = (acc_kind == 2'd2) ? 1 : 0;
        e_hit = 0; e_page = 0; e_r = 0; e_w = 0; e_x = 0;
        for (int i = 0; i < NE; i++) begin
            if (!e_hit) begin
                u = m_up[side][i];
                l = m_lo[side][i];
                if (legacy_mode) begin
                    v  = l[6];
                    m  = 32'hFFFE0000 & ~((l & 32'h3F) << 17);
                    k  = user_mode ? u[2] : u[3];
                    pp = u[1:0];
                    r  = !(k && pp == 2'b00);
                    w  = k ? (pp == 2'b10) : (pp != 2'b11);
                end else begin
                    v  = user_mode ? u[0] : u[1];
                    m  = 32'hFFFE0000 & ~((u & 32'h1FFC) << 15);
                    pp = l[1:0];
                    r  = (pp != 2'b00);
                    w  = (pp == 2'b10);
                end
                if (v && ((eff_addr & m) == (u & 32'hFFFE0000))) begin
                    e_hit  = 1;
                    e_page = ((l & m) | (eff_addr & ~m)) & 32'hFFFFF000;
                    e_r = r; e_w = w; e_x = r;
                end
            end
        end
        case (acc_kind)
            2'd1:    ok = e_w;
            2'd2:    ok = e_x;
            default: ok = e_r;
        endcase
        e_fault = e_hit && !ok;
        e_code  = !e_fault ? 32'h0 : (acc_kind == 2'd1 ? 32'h0A000000 : 32'h08000000);
    endtask

    task automatic compare_all();
        model_eval();
        check("R4 hit", {31'b0, hit}, {31'b0, e_hit});
        check("R5 real_page", real_page, e_page);
        check(legacy_mode ? "R7 perms" : "R6 perms",
              {29'b0, perm_rd, perm_wr, perm_ex}, {29'b0, e_r, e_w, e_x});
        check("R8 fault", {31'b0, prot_fault}, {31'b0, e_fault});
        check("R8 fault_code", fault_code, e_code);
        check("R9 fault_addr", fault_addr, m_faddr);
    endtask

    // one clock: compare settled outputs, then advance the model at the edge
    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        if (rst_n && cfg_wr_en) begin
            if (cfg_wr_lower) m_lo[cfg_wr_fetch_side][cfg_wr_idx] = cfg_wr_data;
            else              m_up[cfg_wr_fetch_side][cfg_wr_idx] = cfg_wr_data;
        end
        if (rst_n && e_fault && acc_kind != 2'd2) m_faddr = eff_addr;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic put(input logic side, input int idx, input logic low, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_fetch_side = side; cfg_wr_idx = 2'(idx);
        cfg_wr_lower = low; cfg_wr_data = d;
        cycle();
    endtask

    task automatic ask(input logic leg, input logic usr, input logic [1:0] k, input logic [31:0] a);
        legacy_mode = leg; user_mode = usr; acc_kind = k; eff_addr = a;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NE; i++) begin m_up[s][i] = 0; m_lo[s][i] = 0; end
        m_faddr = 0;
        @(negedge clk); @(negedge clk);
        ask(0, 0, 0, 32'h1000_1234);
        check("R2 reset no hit", {31'b0, hit}, 32'h0);
        check("R2 reset fault_addr", fault_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // data entry 0: 128 KB block at 0x10000000, both privileges, read/write
        put(0, 0, 0, 32'h1000_0003);
        put(0, 0, 1, 32'h2000_0002);
        ask(0, 0, 0, 32'h1000_1234);
        check("R1 data side hit", {31'b0, hit}, 32'h1);
        check("R5 page", real_page, 32'h2000_1000);
        cycle();
        ask(0, 0, 2, 32'h1000_1234);
        check("R1 fetch ignores data array", {31'b0, hit}, 32'h0);
        cycle();

        // supervisor-only valid bit
        put(0, 0, 0, 32'h1000_0002);
        ask(0, 1, 0, 32'h1000_1234);
        check("R3 user blocked", {31'b0, hit}, 32'h0);
        cycle();
        ask(0, 0, 1, 32'h1000_1234);
        check("R3 supervisor passes", {31'b0, hit}, 32'h1);
        cycle();

        // overlapping entry 1 with another real page
        put(0, 1, 0, 32'h1000_0003);
        put(0, 1, 1, 32'h3000_0002);
        ask(0, 0, 0, 32'h1001_F000);
        check("R10 lowest wins", real_page, 32'h2001_F000);
        cycle();
        ask(0, 1, 0, 32'h1001_F000);
        check("R10 entry 1 when 0 inactive", real_page, 32'h3001_F000);
        cycle();

        // entry 2: 256 MB read-only block
        put(0, 2, 0, 32'h4000_1FFF);
        put(0, 2, 1, 32'h5000_0001);
        ask(0, 1, 0, 32'h4ABC_D123);
        check("R4 long block", real_page, 32'h5ABC_D000);
        cycle();
        ask(0, 1, 1, 32'h4ABC_D123);
        check("R8 store code", fault_code, 32'h0A00_0000);
        cycle();
        check("R9 captured", fault_addr, 32'h4ABC_D123);
        ask(0, 1, 0, 32'h5000_0000);
        cycle();
        check("R9 held", fault_addr, 32'h4ABC_D123);

        // entry 3 in legacy layout: Ks=1 Kp=0 pp=01, valid, smallest block
        put(0, 3, 0, 32'h6000_0009);
        put(0, 3, 1, 32'h7000_0040);
        ask(1, 0, 1, 32'h6001_2345);
        check("R7 supervisor key1 read-only", {31'b0, prot_fault}, 32'h1);
        check("R7 page", real_page, 32'h7001_2000);
        cycle();
        ask(1, 1, 1, 32'h6001_2345);
        check("R7 user key0 writable", {31'b0, prot_fault}, 32'h0);
        cycle();
        ask(1, 0, 0, 32'h1000_1234);
        check("R7 normal entries invalid in legacy", {31'b0, hit}, 32'h0);
        cycle();

        // instruction array: fetch with no execute
        put(1, 0, 0, 32'h8000_0003);
        put(1, 0, 1, 32'h9000_0000);
        ask(0, 0, 2, 32'h8000_4000);
        check("R8 fetch code", fault_code, 32'h0800_0000);
        cycle();
        check("R9 fetch not captured", fault_addr, 32'h6001_2345);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 4) == 0) begin
                cfg_wr_en = 1'b1;
                cfg_wr_fetch_side = 1'($urandom_range(0, 1));
                cfg_wr_idx = 2'($urandom_range(0, NE - 1));
                cfg_wr_lower = 1'($urandom_range(0, 1));
                if (cfg_wr_lower)
                    cfg_wr_data = $urandom() & 32'hFFFE_007F;
                else
                    cfg_wr_data = ($urandom() & 32'hFFFE_000F)
                                | (($urandom_range(0, 3) == 0) ? ($urandom() & 32'h1FFC) : 32'h0);
            end
            legacy_mode = 1'($urandom_range(0, 3) == 0);
            user_mode   = 1'($urandom_range(0, 1));
            acc_kind    = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1)
                eff_addr = (m_up[acc_kind == 2'd2][$urandom_range(0, NE - 1)] & 32'hFFFE0000)
                         | ($urandom() & 32'h0001FFFF);
            else
                eff_addr = $urandom();
            cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule